// File: doc/BRIEF.md
# Self-Configuring Parallel Flash Sector Programmer

This block is a host-side sequencer for a byte-wide parallel flash with an SRAM-like bus. After a start pulse it first finds out which device is attached. It issues the identification-entry command triplet, waits the long write-cycle time, reads the device code, and then leaves identification mode with a second triplet and another long wait. The code sets the sector length (256 or 512 bytes) and the post-write wait (10 ms or 20 ms). The controller keeps this setting, so later start pulses go straight to programming.

Programming one sector takes five steps. The controller sends the protected-write unlock triplet, then fetches every byte of the sector from a local buffer with a one-cycle read latency. It writes the bytes in index order to the sector chosen by the `sector` input, and waits the configured write-cycle time. It then pulses `done`. If the code is not recognised, the controller raises `err` and returns to idle without writing any data.

The states are ST_IDLE, ST_CMD (one triplet), ST_ID_WAIT, ST_ID_READ, ST_EXIT_WAIT, ST_CHECK, ST_FETCH, ST_LOAD, ST_PROG_WAIT and ST_DONE. The transitions are:
- ST_IDLE to ST_CMD on start.
- ST_CMD to ST_ID_WAIT, ST_EXIT_WAIT or ST_FETCH after its third write, depending on the triplet.
- ST_ID_WAIT to ST_ID_READ on timer expiry.
- ST_ID_READ to ST_CMD (exit triplet) on read completion.
- ST_EXIT_WAIT to ST_CHECK on expiry.
- ST_CHECK to ST_CMD (unlock triplet) for a known code, or to ST_IDLE for an unknown one.
- ST_FETCH to ST_LOAD.
- ST_LOAD back to ST_FETCH, or to ST_PROG_WAIT after the last byte.
- ST_PROG_WAIT to ST_DONE on expiry.
- ST_DONE to ST_IDLE.

Top module: `flash_autoprog`

## Requirements
- R1: Out of reset, `f_ce_n`, `f_oe_n` and `f_we_n` are high, and `busy`, `done` and `err` are low.
- R2: With no stored setting, the first writes after start are data AAh to 05555h, 55h to 02AAAh and 90h to 05555h. At least CLK_HZ/50 cycles then pass before the next bus access.
- R3: The device code is read from address 00001h with `f_ce_n` and `f_oe_n` low, in exactly one read per detection.
- R4: After the read, the writes AAh to 05555h, 55h to 02AAAh and F0h to 05555h follow.
- R5: Code 5Bh selects 512-byte sectors with the short wait, A4h 256 bytes short, 3Bh 512 bytes long, and C4h 256 bytes long. The number of data writes equals the sector length.
- R6: Each sector load is preceded by the writes AAh to 05555h, 55h to 02AAAh and A0h to 05555h.
- R7: Data byte i is read from buffer address i and written to address {sector[9:0], i[8:0]} for 512-byte sectors, or {sector[10:0], i[7:0]} for 256-byte sectors. The bytes go in ascending order, and each buffer read strobe lasts one cycle.
- R8: `done` pulses for one cycle, between T and T+3 cycles after the last write strobe ends. T is CLK_HZ/100 for the short wait and CLK_HZ/50 for the long wait.
- R9: Once a known code has been stored, a later start issues no identification commands and no reads. It writes only the unlock triplet and the sector data.
- R10: An unknown code sets `err` and returns to idle after the exit triplet, with no unlock or data write and no `done`. `err` clears on the next start.
- R11: Each write holds `f_ce_n` and `f_we_n` low for exactly PULSE_CYC cycles with address and data stable. `f_we_n` and `f_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken in idle |
| sector | input | 11 | Target sector number |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown device code seen |
| buf_rd | output | 1 | Buffer read strobe |
| buf_addr | output | 9 | Buffer byte index |
| buf_data | input | 8 | Buffer data, valid one cycle after strobe |
| f_addr | output | 19 | Flash address |
| f_wdata | output | 8 | Flash write data |
| f_rdata | input | 8 | Flash read data |
| f_ce_n | output | 1 | Flash chip enable, active low |
| f_oe_n | output | 1 | Flash output enable, active low |
| f_we_n | output | 1 | Flash write enable, active low |

## Verification
The programming path is tried with each of the four recognised codes. Each code uses a different sector number, so both sector lengths are distinguished by the write count and address packing, and both wait lengths by the delay to `done`. An unrecognised code shows that no data is written on the error path. A second start without reset shows that the stored setting bypasses identification. A fixed per-index buffer pattern exposes any byte that is misordered or fetched from the wrong address.

// File: rtl/flash_autoprog_pkg.sv
package flash_autoprog_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int SECT_W = ADDR_W - 8;
    localparam int IDX_W  = 9;

    localparam logic [ADDR_W-1:0] CMD_ADDR_A = 19'h05555;
    localparam logic [ADDR_W-1:0] CMD_ADDR_B = 19'h02AAA;
    localparam logic [ADDR_W-1:0] DEV_CODE_ADDR = 19'h00001;
    localparam logic [DATA_W-1:0] KEY_A = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_B = 8'h55;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_ID_WAIT, ST_ID_READ, ST_EXIT_WAIT,
        ST_CHECK, ST_FETCH, ST_LOAD, ST_PROG_WAIT, ST_DONE
    } ctl_state_t;

    typedef enum logic [1:0] { SEQ_ENTRY, SEQ_EXIT, SEQ_UNLOCK } seq_kind_t;

    typedef struct packed {
        logic known;
        logic big;
        logic slow;
    } dev_cfg_t;

    function automatic logic [DATA_W-1:0] seq_opcode(seq_kind_t k);
        unique case (k)
            SEQ_ENTRY: return 8'h90;
            SEQ_EXIT:  return 8'hF0;
            default:   return 8'hA0;
        endcase
    endfunction

endpackage

// File: rtl/flash_id_decode.sv
module flash_id_decode
    import flash_autoprog_pkg::*;
(
    input  logic [DATA_W-1:0] code,
    output dev_cfg_t          cfg
);
    always_comb begin
        unique case (code)
            8'h5B:   cfg = '{known: 1'b1, big: 1'b1, slow: 1'b0};
            8'hA4:   cfg = '{known: 1'b1, big: 1'b0, slow: 1'b0};
            8'h3B:   cfg = '{known: 1'b1, big: 1'b1, slow: 1'b1};
            8'hC4:   cfg = '{known: 1'b1, big: 1'b0, slow: 1'b1};
            default: cfg = '{known: 1'b0, big: 1'b0, slow: 1'b0};
        endcase
    end
endmodule

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expired) cnt <= cnt + TW'(1);
    end

    assign expired = run && (cnt == limit - TW'(1));
endmodule

// File: rtl/flash_bus_port.sv
module flash_bus_port
    import flash_autoprog_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] f_rdata,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_wdata,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    typedef enum logic [1:0] { P_IDLE, P_ACT, P_REC } port_state_t;
    port_state_t pst;
    logic [CW-1:0] cnt;
    logic          is_rd;
    logic          last_act;

    assign last_act = (pst == P_ACT) && (cnt == CW'(PULSE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst     <= P_IDLE;
            cnt     <= '0;
            is_rd   <= 1'b0;
            f_addr  <= '0;
            f_wdata <= '0;
            rdata   <= '0;
        end else begin
            unique case (pst)
                P_IDLE: if (req) begin
                    pst     <= P_ACT;
                    cnt     <= '0;
                    is_rd   <= rd;
                    f_addr  <= addr_in;
                    f_wdata <= data_in;
                end
                P_ACT: begin
                    if (last_act) begin
                        pst <= P_REC;
                        if (is_rd) rdata <= f_rdata;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: pst <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        f_ce_n = !(pst == P_ACT);
        f_we_n = !(pst == P_ACT && !is_rd);
        f_oe_n = !(pst == P_ACT && is_rd);
        ack    = (pst == P_REC);
    end

    // R11
    we_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we_n |-> !f_ce_n);
    // R11
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!f_we_n && !f_oe_n));
    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_we_n && $past(!f_we_n)) |-> ($stable(f_addr) && $stable(f_wdata)));
endmodule

// File: rtl/flash_autoprog.sv
module flash_autoprog
    import flash_autoprog_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SECT_W-1:0] sector,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              buf_rd,
    output logic [IDX_W-1:0]  buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    output logic [ADDR_W-1:0] f_addr,
    output logic [DATA_W-1:0] f_wdata,
    input  logic [DATA_W-1:0] f_rdata,
    output logic              f_ce_n,
    output logic              f_oe_n,
    output logic              f_we_n
);
    localparam int T_FAST = CLK_HZ / 100;
    localparam int T_SLOW = CLK_HZ / 50;
    localparam int TW     = $clog2(T_SLOW + 1);

    ctl_state_t        state, nxt;
    seq_kind_t         seq;
    logic [1:0]        step;
    logic [IDX_W-1:0]  idx;
    dev_cfg_t          cfg, dec_cfg;
    logic [DATA_W-1:0] id_q;
    logic              err_q;

    logic              port_req, port_rd, port_ack;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data, port_rdata;
    logic              tmr_run, tmr_exp;
    logic [TW-1:0]     tmr_lim;
    logic              last_step, last_byte;
    logic [ADDR_W-1:0] data_addr;

    assign last_step = (step == 2'd2);
    assign last_byte = cfg.big ? (idx == 9'h1FF) : (idx[7:0] == 8'hFF);
    assign data_addr = cfg.big ? {sector[SECT_W-2:0], idx} : {sector, idx[7:0]};

    flash_id_decode dec_i (.code(id_q), .cfg(dec_cfg));

    flash_wait_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmr_lim), .expired(tmr_exp)
    );

    flash_bus_port #(.PULSE_CYC(PULSE_CYC)) port_i (
        .clk(clk), .rst_n(rst_n), .req(port_req), .rd(port_rd),
        .addr_in(req_addr), .data_in(req_data), .ack(port_ack), .rdata(port_rdata),
        .f_rdata(f_rdata), .f_addr(f_addr), .f_wdata(f_wdata),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_CMD;
            ST_CMD:       if (port_ack && last_step) begin
                              unique case (seq)
                                  SEQ_ENTRY: nxt = ST_ID_WAIT;
                                  SEQ_EXIT:  nxt = ST_EXIT_WAIT;
                                  default:   nxt = ST_FETCH;
                              endcase
                          end
            ST_ID_WAIT:   if (tmr_exp) nxt = ST_ID_READ;
            ST_ID_READ:   if (port_ack) nxt = ST_CMD;
            ST_EXIT_WAIT: if (tmr_exp) nxt = ST_CHECK;
            ST_CHECK:     nxt = dec_cfg.known ? ST_CMD : ST_IDLE;
            ST_FETCH:     nxt = ST_LOAD;
            ST_LOAD:      if (port_ack) nxt = last_byte ? ST_PROG_WAIT : ST_FETCH;
            ST_PROG_WAIT: if (tmr_exp) nxt = ST_DONE;
            ST_DONE:      nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq   <= SEQ_ENTRY;
            step  <= '0;
            idx   <= '0;
            cfg   <= '0;
            id_q  <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    err_q <= 1'b0;
                    step  <= '0;
                    idx   <= '0;
                    seq   <= cfg.known ? SEQ_UNLOCK : SEQ_ENTRY;
                end
                ST_CMD: if (port_ack) step <= last_step ? 2'd0 : step + 2'd1;
                ST_ID_READ: if (port_ack) begin
                    id_q <= port_rdata;
                    seq  <= SEQ_EXIT;
                    step <= '0;
                end
                ST_CHECK: begin
                    if (dec_cfg.known) begin
                        cfg  <= dec_cfg;
                        seq  <= SEQ_UNLOCK;
                        step <= '0;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                ST_LOAD: if (port_ack && !last_byte) idx <= idx + IDX_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        err      = err_q;
        buf_rd   = (state == ST_FETCH);
        buf_addr = idx;
        port_req = (state == ST_CMD) || (state == ST_ID_READ) || (state == ST_LOAD);
        port_rd  = (state == ST_ID_READ);
        tmr_run  = (state == ST_ID_WAIT) || (state == ST_EXIT_WAIT) || (state == ST_PROG_WAIT);
        tmr_lim  = (state == ST_PROG_WAIT && !cfg.slow) ? TW'(T_FAST) : TW'(T_SLOW);
        req_addr = '0;
        req_data = '0;
        unique case (state)
            ST_CMD: begin
                if (step == 2'd1) begin
                    req_addr = CMD_ADDR_B;
                    req_data = KEY_B;
                end else begin
                    req_addr = CMD_ADDR_A;
                    req_data = (step == 2'd0) ? KEY_A : seq_opcode(seq);
                end
            end
            ST_ID_READ: req_addr = DEV_CODE_ADDR;
            ST_LOAD: begin
                req_addr = data_addr;
                req_data = buf_data;
            end
            default: ;
        endcase
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> f_we_n);
    // R7
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !buf_rd);
    // R9
    no_read_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_oe_n |-> !cfg.known);
endmodule

// File: tb/flash_autoprog_tb_top.sv
module flash_autoprog_tb_top;
    localparam int CLK_HZ = 10000;
    localparam int PULSE  = 3;
    localparam int T_FAST = CLK_HZ / 100;
    localparam int T_SLOW = CLK_HZ / 50;
    localparam int LOGN   = 700;

    typedef struct packed {
        logic [7:0]  id;
        logic [10:0] sect;
        logic [9:0]  size;
        logic        slow;
        logic        bad;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{id: 8'h5B, sect: 11'h2A5, size: 10'd512, slow: 1'b0, bad: 1'b0},
        '{id: 8'hA4, sect: 11'h7C3, size: 10'd256, slow: 1'b0, bad: 1'b0},
        '{id: 8'h3B, sect: 11'h013, size: 10'd512, slow: 1'b1, bad: 1'b0},
        '{id: 8'hC4, sect: 11'h400, size: 10'd256, slow: 1'b1, bad: 1'b0},
        '{id: 8'h77, sect: 11'h001, size: 10'd0,   slow: 1'b0, bad: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] sector = '0;
    logic        busy, done, err, buf_rd;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_q = '0;
    logic [18:0] f_addr;
    logic [7:0]  f_wdata, f_rdata;
    logic        f_ce_n, f_oe_n, f_we_n;
    logic [7:0]  dev_id = 8'h5B;

    int n_chk = 0, n_err = 0;
    int cyc = 0, nw = 0, nrd = 0, we_len = 0, pulse_bad = 0, ndone = 0;
    int done_cyc = 0, oe_fall = 0;
    logic [18:0] wa [LOGN];
    logic [7:0]  wd [LOGN];
    int          wr_rise [LOGN];
    logic [18:0] rd_addr = '0;
    bit we_low_prev = 0, oe_low_prev = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'h5A ^ 8'(i >> 8);
    endfunction

    always @(posedge clk) if (buf_rd) buf_q <= pat(int'(buf_addr));
    assign f_rdata = (f_addr == 19'h1) ? dev_id : ((f_addr == 19'h0) ? 8'h1F : 8'hFF);

    flash_autoprog #(.CLK_HZ(CLK_HZ), .PULSE_CYC(PULSE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sector(sector),
        .busy(busy), .done(done), .err(err), .buf_rd(buf_rd), .buf_addr(buf_addr),
        .buf_data(buf_q), .f_addr(f_addr), .f_wdata(f_wdata), .f_rdata(f_rdata),
        .f_ce_n(f_ce_n), .f_oe_n(f_oe_n), .f_we_n(f_we_n)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!f_we_n) we_len = we_len + 1;
        else if (we_low_prev) begin
            if (nw < LOGN) begin
                wa[nw] = f_addr; wd[nw] = f_wdata; wr_rise[nw] = cyc;
            end
            nw = nw + 1;
            if (we_len != PULSE) pulse_bad = pulse_bad + 1;
            we_len = 0;
        end
        if (!f_oe_n && !oe_low_prev) begin
            nrd = nrd + 1; rd_addr = f_addr; oe_fall = cyc;
        end
        if (done) begin ndone = ndone + 1; done_cyc = cyc; end
        we_low_prev = !f_we_n;
        oe_low_prev = !f_oe_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0; nrd = 0; ndone = 0; pulse_bad = 0; we_len = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_op();
        int t = 0;
        clear_log();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        chk(t < 20000, "watchdog: operation did not finish", t, 20000);
        repeat (2) @(negedge clk);
    endtask

    function automatic bit triplet_ok(int b, logic [7:0] op);
        return wa[b] == 19'h05555 && wd[b] == 8'hAA && wa[b+1] == 19'h02AAA &&
               wd[b+1] == 8'h55 && wa[b+2] == 19'h05555 && wd[b+2] == op;
    endfunction

    function automatic int data_mism(int b, vec_t v);
        int m = 0;
        for (int i = 0; i < int'(v.size); i++) begin
            logic [18:0] ea;
            ea = (v.size == 10'd512) ? {v.sect[9:0], 9'(i)} : {v.sect, 8'(i)};
            if (wa[b+i] !== ea || wd[b+i] !== pat(i)) m++;
        end
        return m;
    endfunction

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(f_ce_n && f_oe_n && f_we_n, "R1 bus idle in reset", {f_ce_n, f_oe_n, f_we_n}, 3'b111);
        chk(!busy && !done && !err, "R1 status low in reset", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 5; k++) begin
            vec_t v;
            int t_exp, gap, dly;
            v = VECS[k];
            do_reset();
            dev_id = v.id;
            sector = v.sect;
            run_op();
            chk(triplet_ok(0, 8'h90), "R2 entry triplet", wd[2], 8'h90);
            gap = oe_fall - wr_rise[2];
            chk(gap >= T_SLOW, "R2 wait after entry", gap, T_SLOW);
            chk(nrd == 1 && rd_addr == 19'h1, "R3 single code read at 00001h", int'(rd_addr), 1);
            chk(triplet_ok(3, 8'hF0), "R4 exit triplet", wd[5], 8'hF0);
            chk(pulse_bad == 0, "R11 write pulse width", pulse_bad, 0);
            if (v.bad) begin
                chk(nw == 6, "R10 no writes past exit", nw, 6);
                chk(err == 1'b1, "R10 err raised", err, 1);
                chk(ndone == 0, "R10 no done", ndone, 0);
            end else begin
                chk(nw == 9 + int'(v.size), "R5 sector length", nw - 9, int'(v.size));
                chk(triplet_ok(6, 8'hA0), "R6 unlock triplet", wd[8], 8'hA0);
                chk(data_mism(9, v) == 0, "R7 data address/order", data_mism(9, v), 0);
                t_exp = v.slow ? T_SLOW : T_FAST;
                dly = done_cyc - wr_rise[nw - 1];
                chk(ndone == 1 && dly >= t_exp && dly <= t_exp + 3, "R8 R5 post-write wait", dly, t_exp + 1);
                chk(err == 1'b0, "R10 err low on success", err, 0);
            end
        end

        // R10 err clears on next start; R9 stored config skips detection
        begin
            vec_t v2;
            dev_id = 8'hC4;
            sector = 11'h123;
            do_reset();
            run_op();
            dev_id = 8'h5B;
            v2 = '{id: 8'hC4, sect: 11'h155, size: 10'd256, slow: 1'b1, bad: 1'b0};
            sector = v2.sect;
            run_op();
            chk(nw == 3 + 256 && nrd == 0, "R9 no identification on reuse", nw, 259);
            chk(triplet_ok(0, 8'hA0), "R9 R6 unlock first", wd[2], 8'hA0);
            chk(data_mism(3, v2) == 0, "R9 R7 data on reuse", data_mism(3, v2), 0);
            chk(ndone == 1, "R8 done once on reuse", ndone, 1);
        end

        begin
            dev_id = 8'h00;
            do_reset();
            run_op();
            chk(err == 1'b1, "R10 err set before restart", err, 1);
            dev_id = 8'hA4;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(err == 1'b0, "R10 err cleared by start", err, 0);
            while (busy) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule